// File: doc/BRIEF.md
# Macro Processor Arithmetic Unit with Persistent Carry

This unit is the 32-bit arithmetic and logic stage of a small command-stream macro processor. Each cycle it takes two operands and a 5-bit operation code and returns a result at once. It keeps one carry bit from one instruction to the next. That bit lets multi-word additions and subtractions be chained one instruction at a time. The carry register is the only state. The result and the illegal-operation flag are combinational functions of the present inputs and the stored carry.

Decode of the wider instruction, the register file and the routing of the result all sit outside this unit. The surrounding pipeline raises the enable strobe when an instruction really executes. The stored carry changes only on those cycles.

For subtraction the carry works as a "no borrow" indicator. It is set when the minuend is at least as large as everything taken away from it. Subtract-with-borrow removes one extra unit when the stored carry is clear.

Top module: `macro_alu`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, clears the stored carry, so `carryOut` reads 0 after that edge.
- R2: Code 0 (add) gives result = (A + B) mod 2^32. On an enabled edge the carry takes the 33rd bit of the sum, that is 1 when A + B > 2^32 - 1.
- R3: Code 1 (add with carry) gives result = (A + B + carry) mod 2^32, with the carry taken before the edge. On an enabled edge the carry becomes 1 exactly when A + B + carry > 2^32 - 1.
- R4: Code 2 (subtract) gives result = (A - B) mod 2^32. On an enabled edge the carry becomes 1 exactly when A >= B (unsigned).
- R5: Code 3 (subtract with borrow) gives result = (A - B - 1) mod 2^32 when the carry is clear and (A - B) mod 2^32 when it is set. On an enabled edge the carry becomes 1 exactly when that exact difference is not negative.
- R6: Bitwise codes give: 8 gives A XOR B, 9 gives A OR B, 10 gives A AND B, 11 gives A AND (NOT B), 12 gives NOT (A AND B).
- R7: Codes 8 to 12 never change the stored carry.
- R8: Any code outside 0-3 and 8-12 (that is 4-7 and 13-31) gives result 0 and leaves the carry unchanged. For such a code, `illegalOp` is 1 in the same cycle while `en` is 1, and 0 while `en` is 0. For a valid code `illegalOp` is always 0.
- R9: While `en` is 0 the stored carry holds its value whatever the code and operands. The result is still computed from the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the carry |
| en | input | 1 | Instruction executes this cycle; allows the carry update |
| opCode | input | 5 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| carryOut | output | 1 | Stored carry flag |
| illegalOp | output | 1 | Invalid code presented while enabled |

## Verification
`result` and `illegalOp` are combinational, so they are due in the same cycle as the inputs that cause them. The carry produced by an instruction shows on `carryOut` only after the next rising edge, one cycle later. The bench drives inputs on the falling edge and compares the combinational outputs shortly after, against the model's carry of that moment. It then moves its model carry forward at the rising edge, so the next comparison of `carryOut` checks the value written by the previous enabled instruction.

// File: rtl/macro_alu_pkg.sv
`timescale 1ns/1ps
package macro_alu_pkg;

  typedef enum logic [2:0] {
    LG_XOR  = 3'd0,
    LG_OR   = 3'd1,
    LG_AND  = 3'd2,
    LG_ANDN = 3'd3,
    LG_NAND = 3'd4
  } logicSel_e;

  // Strobes passed from decode control to the datapath.
  typedef struct packed {
    logic      arith;        // result comes from the adder
    logic      invertB;      // adder sees ~B (subtract forms)
    logic      cinFromCarry; // adder carry-in is the stored carry
    logic      cinConst;     // fixed carry-in when not from stored carry
    logicSel_e logicSel;     // bitwise function select
    logic      illegal;      // code is a hole in the encoding
    logic      carryWrite;   // update stored carry at this edge
  } aluStrobes_t;

endpackage

// File: rtl/macro_alu_ctrl.sv
`timescale 1ns/1ps
module macro_alu_ctrl
  import macro_alu_pkg::*;
#(
  parameter int OP_W = 5
) (
  input  logic            en,
  input  logic [OP_W-1:0] opCode,
  output aluStrobes_t     strobes,
  output logic            illegalOp
);

  always_comb begin
    strobes = '{arith: 1'b0, invertB: 1'b0, cinFromCarry: 1'b0, cinConst: 1'b0,
                logicSel: LG_XOR, illegal: 1'b0, carryWrite: 1'b0};
    case (opCode)
      OP_W'(0): strobes.arith = 1'b1;
      OP_W'(1): begin
        strobes.arith        = 1'b1;
        strobes.cinFromCarry = 1'b1;
      end
      OP_W'(2): begin
        strobes.arith    = 1'b1;
        strobes.invertB  = 1'b1;
        strobes.cinConst = 1'b1;
      end
      OP_W'(3): begin
        strobes.arith        = 1'b1;
        strobes.invertB      = 1'b1;
        strobes.cinFromCarry = 1'b1;
      end
      OP_W'(8):  strobes.logicSel = LG_XOR;
      OP_W'(9):  strobes.logicSel = LG_OR;
      OP_W'(10): strobes.logicSel = LG_AND;
      OP_W'(11): strobes.logicSel = LG_ANDN;
      OP_W'(12): strobes.logicSel = LG_NAND;
      default:   strobes.illegal  = 1'b1;
    endcase
    strobes.carryWrite = en & strobes.arith;
  end

  assign illegalOp = en & strobes.illegal;

  // R7: bitwise and illegal codes never request a carry write
  always_comb begin
    assert_no_write_nonarith_R7: assert (strobes.arith || !strobes.carryWrite);
  end

endmodule

// File: rtl/macro_alu_dp.sv
`timescale 1ns/1ps
module macro_alu_dp
  import macro_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              carryQ
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] bOperand;
  logic              carryIn;
  logic [SUM_W-1:0]  sumWide;
  logic [DATA_W-1:0] logicRes;

  // One shared adder: subtract is A + ~B + cin, where cin = 1 means no extra borrow.
  assign bOperand = strobes.invertB ? ~opB : opB;
  assign carryIn  = strobes.cinFromCarry ? carryQ : strobes.cinConst;
  assign sumWide  = {1'b0, opA} + {1'b0, bOperand} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    case (strobes.logicSel)
      LG_XOR:  logicRes = opA ^ opB;
      LG_OR:   logicRes = opA | opB;
      LG_AND:  logicRes = opA & opB;
      LG_ANDN: logicRes = opA & ~opB;
      LG_NAND: logicRes = ~(opA & opB);
      default: logicRes = '0;
    endcase
  end

  always_comb begin
    if (strobes.illegal)    result = '0;
    else if (strobes.arith) result = sumWide[DATA_W-1:0];
    else                    result = logicRes;
  end

  always_ff @(posedge clk) begin
    if (rst)                     carryQ <= 1'b0;
    else if (strobes.carryWrite) carryQ <= sumWide[DATA_W];
  end

  // R9: carry holds when no write strobe was given
  assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.carryWrite |=> $stable(carryQ));

endmodule

// File: rtl/macro_alu.sv
`timescale 1ns/1ps
module macro_alu
  import macro_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              illegalOp
);

  aluStrobes_t strobes;

  macro_alu_ctrl #(.OP_W(OP_W)) uCtrl (
    .en        (en),
    .opCode    (opCode),
    .strobes   (strobes),
    .illegalOp (illegalOp)
  );

  macro_alu_dp #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .carryQ  (carryOut)
  );

  // R8: an illegal strobe always comes with a zero result
  always_comb begin
    if (illegalOp) assert_illegal_zero_R8: assert (result == '0);
  end

  assert_illegal_keeps_carry_R8: assert property (@(posedge clk) disable iff (rst)
    illegalOp |=> $stable(carryOut));

  assert_idle_keeps_carry_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(carryOut));

  assert_logic_keeps_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (en && opCode >= OP_W'(8) && opCode <= OP_W'(12)) |=> $stable(carryOut));

  assert_sub_no_borrow_R4: assert property (@(posedge clk) disable iff (rst)
    (en && opCode == OP_W'(2)) |=> (carryOut == ($past(opA) >= $past(opB))));

  assert_add_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (en && opCode == OP_W'(0)) |=>
      (carryOut == (({1'b0, $past(opA)} + {1'b0, $past(opB)}) > {1'b0, {DATA_W{1'b1}}})));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !carryOut);

endmodule

// File: tb/macro_alu_test.sv
`timescale 1ns/1ps
module macro_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [4:0]  opCode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        carryOut;
  logic        illegalOp;

  int compared = 0;
  int mismatched = 0;
  bit refCarry = 1'b0;
  string carryTag = "R1";
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  macro_alu uut (
    .clk(clk), .rst(rst), .en(en), .opCode(opCode), .opA(opA), .opB(opB),
    .result(result), .carryOut(carryOut), .illegalOp(illegalOp)
  );

  function automatic bit isValid(input logic [4:0] op);
    return (op <= 5'd3) || (op >= 5'd8 && op <= 5'd12);
  endfunction

  function automatic string tagOf(input logic [4:0] op, input bit e);
    if (!isValid(op)) return "R8";
    case (op)
      5'd0: return "R2";
      5'd1: return "R3";
      5'd2: return "R4";
      5'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Behavioural reference: exact integer arithmetic, returns result and next carry.
  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input bit c, output logic [31:0] r, output bit nc, output bit writes);
    longint exact;
    writes = 1'b1;
    nc = c;
    r = '0;
    case (op)
      5'd0: begin exact = longint'(a) + longint'(b); nc = exact > 64'sd4294967295; end
      5'd1: begin exact = longint'(a) + longint'(b) + (c ? 1 : 0); nc = exact > 64'sd4294967295; end
      5'd2: begin exact = longint'(a) - longint'(b); nc = exact >= 0; end
      5'd3: begin exact = longint'(a) - longint'(b) - (c ? 0 : 1); nc = exact >= 0; end
      default: begin exact = 0; writes = 1'b0; end
    endcase
    if (op <= 5'd3) r = exact[31:0];
    else if (op == 5'd8)  r = a ^ b;
    else if (op == 5'd9)  r = a | b;
    else if (op == 5'd10) r = a & b;
    else if (op == 5'd11) r = a & ~b;
    else if (op == 5'd12) r = ~(a & b);
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit e, input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] expR;
    bit nc, writes;
    @(negedge clk);
    en = e; opCode = op; opA = a; opB = b;
    #1;
    model(op, a, b, refCarry, expR, nc, writes);
    check(tagOf(op, e), "result", result, expR);
    check("R8", "illegalOp", {31'd0, illegalOp}, {31'd0, (e && !isValid(op))});
    check(carryTag, "carryOut", {31'd0, carryOut}, {31'd0, refCarry});
    @(posedge clk);
    if (e && writes) refCarry = nc;
    if (!e) carryTag = "R9";
    else if (!isValid(op)) carryTag = "R8";
    else if (!writes) carryTag = "R7";
    else carryTag = tagOf(op, e);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    @(posedge clk);
    refCarry = 1'b0;
    carryTag = "R1";
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "carryOut after reset", {31'd0, carryOut}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset();
    // R2: overflow and no overflow
    step(1, 5'd0, 32'hFFFF_FFFF, 32'h1);
    step(1, 5'd0, 32'h1234_0000, 32'h0000_5678);
    // R3: carry-in used
    step(1, 5'd0, 32'h8000_0000, 32'h8000_0000);
    step(1, 5'd1, 32'h1, 32'h1);
    step(1, 5'd1, 32'hFFFF_FFFF, 32'h0);
    step(1, 5'd1, 32'hFFFF_FFFF, 32'h0);
    // R4: A>=B, A<B, equal
    step(1, 5'd2, 32'd5, 32'd3);
    step(1, 5'd2, 32'd3, 32'd5);
    step(1, 5'd2, 32'd7, 32'd7);
    // R5: with clear and set carry
    step(1, 5'd2, 32'd0, 32'd1);
    step(1, 5'd3, 32'd10, 32'd3);
    step(1, 5'd3, 32'd0, 32'd0);
    step(1, 5'd3, 32'd0, 32'd1);
    step(1, 5'd3, 32'd0, 32'd0);
    step(1, 5'd3, 32'd1, 32'd0);
    // R6/R7: bitwise with carry set then clear
    step(1, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int k = 8; k <= 12; k++) step(1, 5'(k), 32'hF0F0_1234, 32'h0FF0_FF00);
    step(1, 5'd2, 32'd1, 32'd2);
    for (int k = 8; k <= 12; k++) step(1, 5'(k), 32'hA5A5_5A5A, 32'h3C3C_C3C3);
    // R8: holes and high codes, enabled and not
    step(1, 5'd0, 32'hFFFF_FFFF, 32'd1);
    for (int k = 4; k <= 7; k++) step(1, 5'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 5'd13, 32'hDEAD_BEEF, 32'h1);
    step(1, 5'd31, 32'h1, 32'h1);
    step(0, 5'd6, 32'h1, 32'h1);
    // R9: disabled arithmetic leaves carry
    step(0, 5'd2, 32'd0, 32'd1);
    step(0, 5'd1, 32'd0, 32'd0);
    step(1, 5'd2, 32'd0, 32'd1);
    step(0, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(0, 5'd3, 32'd9, 32'd1);
    // R1: reset with carry set
    step(1, 5'd0, 32'hFFFF_FFFF, 32'h2);
    step(1, 5'd9, 32'd0, 32'd0);
    doReset();
    // mixed random stream
    for (int n = 0; n < 400; n++) begin
      logic [4:0] op;
      logic [31:0] a, b;
      op = 5'($urandom_range(0, 15));
      a = $urandom;
      b = (n % 4 == 0) ? a : $urandom;
      step(($urandom_range(0, 5) != 0), op, a, b);
    end
    step(0, 5'd0, 32'd0, 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule